// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge-Detect Interrupts

This block is an eight-pin general-purpose port behind a small register interface. Each pin is set up on its own. It can be a discrete input, a discrete output, or an edge-detect input. An edge-detect input watches for a chosen transition and latches it in a sticky flag. While any flag is set and a nonzero priority level is programmed, the port presents that level as an interrupt request. During a matching acknowledge cycle, it returns a programmable 8-bit vector.

Software reaches the port through a register bus with a 4-bit address, write and read strobes, and combinational read data. The data register answers at two addresses, and both behave the same way. Pins are resynchronised through two flops before they are read back or checked for edges. A flag is cleared only by a read that sees it set, followed by a write of 0 to that bit.

Register addresses: 0 and 1 data, 2 direction, 3 pin function, 4 edge select for pins 0-3, 5 edge select for pins 4-7, 6 flags, 7 level, 8 vector.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, the data latch, direction, pin function, edge selects, flags and level all read 0. The vector reads 0x0F. pin_oe is 0, and irq_level is 0. Unused addresses (9-15) read 0.
- R2: A write to address 0 or 1 updates the data latch from the next clock edge. pin_out always shows the latch.
- R3: A data read returns the synchronised pin for each bit whose function bit (address 3) is 0 and whose direction bit is 0. Every other bit returns the latch. A pin change reaches the read path two clocks after it is sampled.
- R4: Addresses 0 and 1 give identical read data, and a write to either one updates the same latch.
- R5: pin_oe bit i is 1 only when direction bit i is 1 and function bit i is 0. A function bit of 1 makes the pin an edge-detect input, and its output driver is off.
- R6: Pin i's edge select is bits [2i+1:2i] of the 16-bit pair at addresses 5:4. The codes are 00 off, 01 falling, 10 rising and 11 both. A flag is set only for a selected edge on a pin whose function bit is 1.
- R7: Flags are sticky. Writing 0 to a flag bit clears it only if a read of address 6 saw that bit set since the bit's last clear-write. Writing 1 has no effect.
- R8: irq_level equals the level register (3 bits, address 7, upper bits read 0) while any flag is set and the level is nonzero. Otherwise it is 0.
- R9: When iack is high, irq_level is nonzero and iack_level equals irq_level, vec_valid is 1 and vec_out shows the vector register. Otherwise vec_valid is 0 and vec_out is 0.
- R10: The direction, function, edge-select, level and vector registers read back what was written. Only the three low bits of the level register are stored.
- R11: If an edge sets a flag in the same cycle as a valid clear-write to that bit, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms flag clearing) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| irq_level | output | 3 | Requested interrupt level, 0 = none |
| iack | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| vec_out | output | 8 | Vector returned on a matching acknowledge |
| vec_valid | output | 1 | vec_out is valid |

## Verification
The assertions assume the bus never writes and reads the flag register in the same cycle. They also assume pins are held low through reset, so the first synchronised sample is not mistaken for a rising edge. The stimulus meets both conditions. It drives strobes and pins only on falling clock edges, and it keeps pins at 0 until reset is released and the edge selects are programmed. Each pin change is given at least four clocks to pass the synchroniser before results are read. The one exception is the same-cycle set/clear case, where the write is placed on the cycle in which the flag sets.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int PORT_W   = 8;
    localparam int LVL_W    = 3;
    localparam int VEC_W    = 8;
    localparam int ADDR_W   = 4;
    localparam int SYNC_N   = 2;
    localparam logic [VEC_W-1:0] VEC_RESET = 8'h0F;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA    = 4'd0,
        RA_DATA_B  = 4'd1,
        RA_DIR     = 4'd2,
        RA_FUNC    = 4'd3,
        RA_ESEL_LO = 4'd4,
        RA_ESEL_HI = 4'd5,
        RA_FLAGS   = 4'd6,
        RA_LEVEL   = 4'd7,
        RA_VECTOR  = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic [PORT_W-1:0]   latch;
        logic [PORT_W-1:0]   dir;
        logic [PORT_W-1:0]   func;
        logic [2*PORT_W-1:0] esel;
        logic [LVL_W-1:0]    level;
        logic [VEC_W-1:0]    vector;
    } port_cfg_t;

    function automatic logic edge_hit(input logic [1:0] mode, input logic cur, input logic prev);
        case (edge_mode_e'(mode))
            EDGE_FALL: edge_hit = prev & ~cur;
            EDGE_RISE: edge_hit = cur & ~prev;
            EDGE_BOTH: edge_hit = cur ^ prev;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

    function automatic logic is_data_addr(input logic [ADDR_W-1:0] a);
        is_data_addr = (a == RA_DATA) || (a == RA_DATA_B);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags
    import gpio_edge_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   pin_s,
    input  logic [2*W-1:0] esel,
    input  logic [W-1:0]   edge_en,
    input  logic [W-1:0]   clr_req,
    output logic [W-1:0]   flags
);
    logic [W-1:0] prev;
    logic [W-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= pin_s;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            assign hit[i] = edge_en[i] & edge_hit(esel[2*i+1:2*i], pin_s[i], prev[i]);

            always_ff @(posedge clk) begin
                if (rst)             flags[i] <= 1'b0;
                else if (hit[i])     flags[i] <= 1'b1;
                else if (clr_req[i]) flags[i] <= 1'b0;
            end

            // R6
            flag_src_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(flags[i]) |-> $past(edge_en[i] && (pin_s[i] != prev[i])));

            // R7
            flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(flags[i]) |-> $past(clr_req[i]));
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_vec.sv
module gpio_irq_vec
    import gpio_edge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_any,
    input  logic [LVL_W-1:0] level,
    input  logic [VEC_W-1:0] vector,
    input  logic             iack,
    input  logic [LVL_W-1:0] iack_level,
    output logic [LVL_W-1:0] irq_level,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid
);
    always_comb begin
        irq_level = (flag_any && level != '0) ? level : '0;
        vec_valid = iack && (irq_level != '0) && (iack_level == irq_level);
        vec_out   = vec_valid ? vector : '0;
    end

    // R9
    vec_match_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (iack && iack_level == level && flag_any));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> (irq_level == '0 && !vec_valid));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [LVL_W-1:0]  irq_level,
    input  logic              iack,
    input  logic [LVL_W-1:0]  iack_level,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid
);
    localparam int ESEL_W = 2 * PORT_W;

    port_cfg_t          cfg;
    logic [PORT_W-1:0]  pin_s;
    logic [PORT_W-1:0]  flags;
    logic [PORT_W-1:0]  armed;
    logic [PORT_W-1:0]  clr_req;
    logic [PORT_W-1:0]  latch_sel;
    logic               wr_flags;

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_s)
    );

    assign wr_flags = reg_wr && (reg_addr == RA_FLAGS);
    assign clr_req  = wr_flags ? (armed & ~reg_wdata[PORT_W-1:0]) : '0;

    gpio_edge_flags #(.W(PORT_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .pin_s   (pin_s),
        .esel    (cfg.esel),
        .edge_en (cfg.func),
        .clr_req (clr_req),
        .flags   (flags)
    );

    gpio_irq_vec u_irq (
        .clk        (clk),
        .rst        (rst),
        .flag_any   (|flags),
        .level      (cfg.level),
        .vector     (cfg.vector),
        .iack       (iack),
        .iack_level (iack_level),
        .irq_level  (irq_level),
        .vec_out    (vec_out),
        .vec_valid  (vec_valid)
    );

    // Register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            cfg.vector <= VEC_RESET;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_DATA, RA_DATA_B: cfg.latch <= reg_wdata[PORT_W-1:0];
                RA_DIR:             cfg.dir   <= reg_wdata[PORT_W-1:0];
                RA_FUNC:            cfg.func  <= reg_wdata[PORT_W-1:0];
                RA_ESEL_LO:         cfg.esel[ESEL_W/2-1:0]      <= reg_wdata;
                RA_ESEL_HI:         cfg.esel[ESEL_W-1:ESEL_W/2] <= reg_wdata;
                RA_LEVEL:           cfg.level <= reg_wdata[LVL_W-1:0];
                RA_VECTOR:          cfg.vector <= reg_wdata[VEC_W-1:0];
                default: ;
            endcase
        end
    end

    // Clear arming: a read records which flags were seen set
    always_ff @(posedge clk) begin
        if (rst)                                   armed <= '0;
        else if (wr_flags)                         armed <= armed & reg_wdata[PORT_W-1:0];
        else if (reg_rd && reg_addr == RA_FLAGS)   armed <= flags;
    end

    // Pin drive and read-back
    assign pin_out   = cfg.latch;
    assign pin_oe    = cfg.dir & ~cfg.func;
    assign latch_sel = cfg.dir | cfg.func;

    always_comb begin
        reg_rdata = '0;
        if (is_data_addr(reg_addr)) begin
            reg_rdata = (pin_s & ~latch_sel) | (cfg.latch & latch_sel);
        end else begin
            case (reg_addr)
                RA_DIR:     reg_rdata = cfg.dir;
                RA_FUNC:    reg_rdata = cfg.func;
                RA_ESEL_LO: reg_rdata = cfg.esel[ESEL_W/2-1:0];
                RA_ESEL_HI: reg_rdata = cfg.esel[ESEL_W-1:ESEL_W/2];
                RA_FLAGS:   reg_rdata = flags;
                RA_LEVEL:   reg_rdata = {{(8-LVL_W){1'b0}}, cfg.level};
                RA_VECTOR:  reg_rdata = cfg.vector;
                default:    reg_rdata = '0;
            endcase
        end
    end

    // R2
    latch_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && is_data_addr(reg_addr)) |=> (pin_out == $past(reg_wdata)));

    // R5
    func_drv_off_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_FUNC) |=> ((pin_oe & $past(reg_wdata)) == '0));

    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |-> (irq_level == '0));
endmodule

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_DATA = 4'd0, A_DATB = 4'd1, A_DIR = 4'd2, A_FUNC = 4'd3,
                           A_ELO = 4'd4, A_EHI = 4'd5, A_FLG = 4'd6, A_LVL = 4'd7, A_VEC = 4'd8;

    logic       clk = 0;
    logic       rst = 1;
    logic [3:0] reg_addr = 0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = 0;
    logic [7:0] pin_out, pin_oe;
    logic [2:0] irq_level;
    logic       iack = 0;
    logic [2:0] iack_level = 0;
    logic [7:0] vec_out;
    logic       vec_valid;

    int vectors = 0;
    int miscomp = 0;
    bit done = 0;

    gpio_edge_port dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_level(irq_level), .iack(iack), .iack_level(iack_level),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        logic [7:0] tmp;
        rd(A_FLG, tmp);
        wr(A_FLG, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscomp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(A_DATA, v); chk("R1 data", v, 8'h00);
        rd(A_DIR, v);  chk("R1 dir", v, 8'h00);
        rd(A_FUNC, v); chk("R1 func", v, 8'h00);
        rd(A_ELO, v);  chk("R1 esel lo", v, 8'h00);
        rd(A_EHI, v);  chk("R1 esel hi", v, 8'h00);
        rd(A_FLG, v);  chk("R1 flags", v, 8'h00);
        rd(A_LVL, v);  chk("R1 level", v, 8'h00);
        rd(A_VEC, v);  chk("R1 vector", v, 8'h0F);
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 irq_level", {5'b0, irq_level}, 8'h00);
        for (int a = 9; a < 16; a++) begin
            rd(a[3:0], v); chk("R1 unused addr", v, 8'h00);
        end

        // R10 register read-back
        wr(A_DIR, 8'hA5);  rd(A_DIR, v);  chk("R10 dir", v, 8'hA5);
        wr(A_FUNC, 8'h3C); rd(A_FUNC, v); chk("R10 func", v, 8'h3C);
        wr(A_ELO, 8'h1B);  rd(A_ELO, v);  chk("R10 esel lo", v, 8'h1B);
        wr(A_EHI, 8'hE4);  rd(A_EHI, v);  chk("R10 esel hi", v, 8'hE4);
        wr(A_LVL, 8'hFD);  rd(A_LVL, v);  chk("R10 level", v, 8'h05);
        wr(A_VEC, 8'h9A);  rd(A_VEC, v);  chk("R10 vector", v, 8'h9A);
        wr(A_ELO, 8'h00); wr(A_EHI, 8'h00); wr(A_LVL, 8'h00);

        // R2 R3 R4 R5: sweep every direction value
        for (int d = 0; d < 256; d++) begin
            logic [7:0] dir, fn, lat, pins, exp;
            dir  = d[7:0];
            fn   = d[7:0] * 8'd37 + 8'd11;
            lat  = ~dir ^ 8'h5A;
            pins = dir ^ 8'hC3;
            wr(A_DIR, dir);
            wr(A_FUNC, fn);
            wr((d % 2 == 0) ? A_DATA : A_DATB, lat);
            pin_in = pins;
            settle();
            exp = (pins & ~dir & ~fn) | (lat & (dir | fn));
            chk("R2 pin_out", pin_out, lat);
            chk("R5 pin_oe", pin_oe, dir & ~fn);
            rd(A_DATA, v);  chk("R3 data read", v, exp);
            rd(A_DATB, v2); chk("R4 alias read", v2, exp);
        end
        pin_in = 0;
        wr(A_DIR, 8'h00); wr(A_FUNC, 8'h00); wr(A_DATA, 8'h00);
        settle();

        // R6: edge select in I/O mode sets nothing
        wr(A_ELO, 8'hFF); wr(A_EHI, 8'hFF);
        pin_in = 8'hFF; settle(); pin_in = 8'h00; settle();
        rd(A_FLG, v); chk("R6 io mode no flag", v, 8'h00);

        // R6: each mode on each pin
        wr(A_FUNC, 8'hFF);
        for (int m = 0; m < 4; m++) begin
            logic [7:0] rep;
            rep = {4{m[1:0]}};
            wr(A_ELO, rep); wr(A_EHI, rep);
            settle();
            rd(A_FLG, v); chk("R6 idle no flag", v, 8'h00);
            for (int i = 0; i < 8; i++) begin
                pin_in[i] = 1'b1; settle();
                rd(A_FLG, v); chk("R6 rising", v, m[1] ? (8'h01 << i) : 8'h00);
                wr(A_FLG, 8'h00);
                rd(A_FLG, v); chk("R7 cleared", v, 8'h00);
                pin_in[i] = 1'b0; settle();
                rd(A_FLG, v); chk("R6 falling", v, m[0] ? (8'h01 << i) : 8'h00);
                wr(A_FLG, 8'h00);
            end
        end
        clear_all();

        // R7 clear protocol (mode both on every pin)
        pin_in[0] = 1'b1; settle();
        wr(A_FLG, 8'h00);
        rd(A_FLG, v); chk("R7 clear without read ignored", v, 8'h01);
        wr(A_FLG, 8'hFF);
        rd(A_FLG, v); chk("R7 write one ignored", v, 8'h01);
        wr(A_FLG, 8'h00);
        rd(A_FLG, v); chk("R7 read then clear", v, 8'h00);
        // flag that sets after the arming read is not cleared
        rd(A_FLG, v);
        pin_in[2] = 1'b1; settle();
        wr(A_FLG, 8'h00);
        rd(A_FLG, v); chk("R7 unarmed bit kept", v, 8'h04);
        wr(A_FLG, 8'h00);
        rd(A_FLG, v); chk("R7 armed bit cleared", v, 8'h00);

        // R11 edge in the clear cycle wins
        pin_in[1] = 1'b1; settle();
        rd(A_FLG, v); chk("R11 setup", v, 8'h02);
        @(negedge clk); pin_in[1] = 1'b0;
        @(negedge clk);
        @(negedge clk); reg_addr = A_FLG; reg_wdata = 8'h00; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
        rd(A_FLG, v); chk("R11 set beats clear", v, 8'h02);

        // R8 R9: level and acknowledge sweep with a flag pending
        for (int l = 0; l < 8; l++) begin
            wr(A_LVL, l[7:0]);
            wr(A_VEC, 8'h40 + l[7:0]);
            chk("R8 irq_level", {5'b0, irq_level}, l[7:0]);
            for (int k = 0; k < 8; k++) begin
                logic hit;
                @(negedge clk); iack = 1; iack_level = k[2:0];
                #1;
                hit = (l != 0) && (k == l);
                chk("R9 vec_valid", {7'b0, vec_valid}, {7'b0, hit});
                chk("R9 vec_out", vec_out, hit ? (8'h40 + l[7:0]) : 8'h00);
                iack = 0;
            end
        end
        wr(A_LVL, 8'h06);
        wr(A_FLG, 8'h00);
        rd(A_FLG, v); wr(A_FLG, 8'h00);
        chk("R8 no flags no request", {5'b0, irq_level}, 8'h00);
        @(negedge clk); iack = 1; iack_level = 3'd6; #1;
        chk("R9 no vector without request", {7'b0, vec_valid}, 8'h00);
        iack = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule